// File: doc/BRIEF.md
# Sector ECC Syndrome Checker and Corrector

This unit judges one 512-byte flash sector protected by a 3-byte Hamming code. A caller presents the three check bytes held in the spare area together with the three bytes recomputed over the data it has just read, and raises a strobe. One clock later the unit gives a 2-bit verdict. When the verdict names a single flipped data bit, the unit also gives the byte offset within the sector and the bit within that byte.

The verdict stays latched until the next strobe. While it holds, the caller can stream bytes from its own sector buffer through a patch port. Each byte is paired with its offset, and the byte at the faulty offset comes back with the faulty bit inverted. All other bytes come back unchanged.

Top module: `ecc_sector_check`

## Requirements
- R1: The syndrome is stored XOR computed, byte for byte. Byte k sits at bits [8k+7:8k] of each 24-bit input. A zero syndrome yields status 2'b00 (clean).
- R2: If all 24 stored bits are 1, the status is 2'b00 whatever the computed bytes are.
- R3: If every bit pair {2i+1, 2i} of the syndrome, i = 0..11, has exactly one bit set, the status is 2'b01 (data bit corrected).
- R4: When the status is 2'b01, the byte offset, MSB first, is syndrome bits {17,15,13,11,9,7,5,3,1}.
- R5: When the status is 2'b01, the bit number, MSB first, is syndrome bits {23,21,19}.
- R6: A syndrome with exactly one bit set yields status 2'b10 (fault in the check bytes only, data left as read).
- R7: Any other non-zero syndrome with stored bytes not all 1 yields status 2'b11 (uncorrectable).
- R8: While the held status is 2'b01 and the patch offset equals the held byte offset, the patch output is the patch input with the held bit number inverted.
- R9: In every other case the patch output equals the patch input, including status 2'b10.
- R10: The result valid flag rises exactly one cycle after the strobe. Status, offset and bit are updated only on a strobe and held otherwise.
- R11: After reset the valid flag is 0, the status is 2'b00, and the offset and bit number are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_valid | input | 1 | Strobe: compare the presented check bytes |
| stored_ecc | input | 24 | Check bytes read from the spare area |
| calc_ecc | input | 24 | Check bytes recomputed over the data |
| res_valid | output | 1 | One-cycle pulse after a strobe |
| status | output | 2 | 00 clean, 01 data fixed, 10 check bytes only, 11 uncorrectable |
| err_byte | output | 9 | Faulty byte offset, meaningful with status 01 |
| err_bit | output | 3 | Faulty bit number, meaningful with status 01 |
| patch_idx | input | 9 | Offset of the byte on the patch port |
| patch_in | input | 8 | Byte fetched from the sector buffer |
| patch_out | output | 8 | Byte after correction |

## Verification
Random syndromes almost never reach the correctable class, because all twelve bit pairs must each carry exactly one set bit. The stimulus therefore builds syndromes from a chosen offset and bit number, covering the corner offsets 0 and 511, every bit number, and random offsets. A random computed value is XORed with that syndrome to form the stored bytes. The latched result is then driven through the patch port at the faulty offset and at its neighbours. Single-bit syndromes are swept over all 24 positions. Stored all-ones patterns are paired with syndromes that would otherwise be correctable.

// File: rtl/ecc_chk_pkg.sv
package ecc_chk_pkg;
  localparam int unsigned ECC_BYTES  = 3;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned SYN_W      = ECC_BYTES * BYTE_W;
  localparam int unsigned LOC_W      = SYN_W / 2;
  localparam int unsigned OFS_W      = 9;
  localparam int unsigned BITNUM_W   = LOC_W - OFS_W;

  typedef enum logic [1:0] {
    ST_CLEAN    = 2'b00,
    ST_DATA_FIX = 2'b01,
    ST_ECC_ONLY = 2'b10,
    ST_FATAL    = 2'b11
  } ecc_status_e;
endpackage

// File: rtl/ecc_syndrome.sv
module ecc_syndrome
  import ecc_chk_pkg::*;
#(
  parameter int unsigned NBYTES = ECC_BYTES,
  parameter int unsigned BW     = BYTE_W
) (
  input  logic [NBYTES*BW-1:0] stored,
  input  logic [NBYTES*BW-1:0] calc,
  output logic [NBYTES*BW-1:0] syn,
  output logic                 blank
);
  logic [NBYTES-1:0] byte_ones;

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    assign syn[k*BW +: BW] = stored[k*BW +: BW] ^ calc[k*BW +: BW];
    assign byte_ones[k]    = &stored[k*BW +: BW];
  end

  assign blank = &byte_ones;
endmodule

// File: rtl/ecc_classify.sv
module ecc_classify
  import ecc_chk_pkg::*;
#(
  parameter int unsigned SW = SYN_W,
  parameter int unsigned OW = OFS_W
) (
  input  logic [SW-1:0]           syn,
  input  logic                    blank,
  output ecc_status_e             verdict,
  output logic [OW-1:0]           ofs,
  output logic [SW/2-OW-1:0]      bitnum
);
  localparam int unsigned NPAIR = SW / 2;

  logic [NPAIR-1:0] pair_ok;
  logic [NPAIR-1:0] loc;
  logic             all_pairs;
  logic             is_zero;
  logic             one_hot;

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    assign pair_ok[i] = syn[2*i+1] ^ syn[2*i];
    assign loc[i]     = syn[2*i+1];
  end

  assign all_pairs = &pair_ok;
  assign is_zero   = (syn == '0);
  assign one_hot   = !is_zero && ((syn & (syn - 1'b1)) == '0);
  assign ofs       = loc[OW-1:0];
  assign bitnum    = loc[NPAIR-1:OW];

  always_comb begin
    if (is_zero || blank)  verdict = ST_CLEAN;
    else if (all_pairs)    verdict = ST_DATA_FIX;
    else if (one_hot)      verdict = ST_ECC_ONLY;
    else                   verdict = ST_FATAL;
  end
endmodule

// File: rtl/ecc_byte_patch.sv
module ecc_byte_patch
  import ecc_chk_pkg::*;
#(
  parameter int unsigned OW = OFS_W,
  parameter int unsigned BNW = BITNUM_W,
  parameter int unsigned BW = BYTE_W
) (
  input  logic        fix_armed,
  input  logic [OW-1:0]  fix_ofs,
  input  logic [BNW-1:0] fix_bit,
  input  logic [OW-1:0]  cur_ofs,
  input  logic [BW-1:0]  din,
  output logic [BW-1:0]  dout
);
  logic [BW-1:0] mask;

  always_comb begin
    mask = '0;
    if (fix_armed && (cur_ofs == fix_ofs)) mask[fix_bit] = 1'b1;
  end

  assign dout = din ^ mask;
endmodule

// File: rtl/ecc_sector_check.sv
module ecc_sector_check
  import ecc_chk_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                chk_valid,
  input  logic [SYN_W-1:0]    stored_ecc,
  input  logic [SYN_W-1:0]    calc_ecc,
  output logic                res_valid,
  output logic [1:0]          status,
  output logic [OFS_W-1:0]    err_byte,
  output logic [BITNUM_W-1:0] err_bit,
  input  logic [OFS_W-1:0]    patch_idx,
  input  logic [BYTE_W-1:0]   patch_in,
  output logic [BYTE_W-1:0]   patch_out
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic [SYN_W-1:0]    syn;
  logic                blank;
  ecc_status_e         verdict;
  logic [OFS_W-1:0]    ofs_c;
  logic [BITNUM_W-1:0] bit_c;

  ecc_syndrome u_syn (
    .stored (stored_ecc),
    .calc   (calc_ecc),
    .syn    (syn),
    .blank  (blank)
  );

  ecc_classify u_cls (
    .syn     (syn),
    .blank   (blank),
    .verdict (verdict),
    .ofs     (ofs_c),
    .bitnum  (bit_c)
  );

  ecc_status_e         st_q, st_d;
  logic [OFS_W-1:0]    ofs_q, ofs_d;
  logic [BITNUM_W-1:0] bit_q, bit_d;
  logic                vld_q, vld_d;

  always_comb begin
    vld_d = chk_valid;
    st_d  = st_q;
    ofs_d = ofs_q;
    bit_d = bit_q;
    if (chk_valid) begin
      st_d  = verdict;
      ofs_d = ofs_c;
      bit_d = bit_c;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vld_q <= 1'b0;
      st_q  <= ST_CLEAN;
      ofs_q <= '0;
      bit_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (chk_valid) begin
        st_q  <= st_d;
        ofs_q <= ofs_d;
        bit_q <= bit_d;
      end
    end
  end

  assign res_valid = vld_q;
  assign status    = st_q;
  assign err_byte  = ofs_q;
  assign err_bit   = bit_q;

  ecc_byte_patch u_patch (
    .fix_armed (st_q == ST_DATA_FIX),
    .fix_ofs   (ofs_q),
    .fix_bit   (bit_q),
    .cur_ofs   (patch_idx),
    .din       (patch_in),
    .dout      (patch_out)
  );
endmodule

// File: rtl/ecc_sector_check_sva.sv
module ecc_sector_check_sva
  import ecc_chk_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                chk_valid,
  input logic [SYN_W-1:0]    stored_ecc,
  input logic [SYN_W-1:0]    calc_ecc,
  input logic                res_valid,
  input logic [1:0]          status,
  input logic [OFS_W-1:0]    err_byte,
  input logic [BITNUM_W-1:0] err_bit,
  input logic [OFS_W-1:0]    patch_idx,
  input logic [BYTE_W-1:0]   patch_in,
  input logic [BYTE_W-1:0]   patch_out
);
  // R10
  strobe_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> res_valid);
  // R10
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> !res_valid);
  // R10
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> ($stable(status) && $stable(err_byte) && $stable(err_bit)));
  // R1
  zero_syn_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && stored_ecc == calc_ecc) |=> status == 2'b00);
  // R2
  blank_page_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && (&stored_ecc)) |=> status == 2'b00);
  // R6
  single_bit_ecc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !(&stored_ecc) && $countones(stored_ecc ^ calc_ecc) == 1)
      |=> status == 2'b10);
  // R9
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status != 2'b01 |-> patch_out == patch_in);
  // R8
  one_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(patch_out ^ patch_in) <= 1);
endmodule

bind ecc_sector_check ecc_sector_check_sva u_sva (.*);

// File: tb/ecc_sector_check_test.sv
`timescale 1ns/1ps
module ecc_sector_check_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chk_valid = 1'b0;
  logic [23:0] stored_ecc = '0;
  logic [23:0] calc_ecc = '0;
  logic        res_valid;
  logic [1:0]  status;
  logic [8:0]  err_byte;
  logic [2:0]  err_bit;
  logic [8:0]  patch_idx = '0;
  logic [7:0]  patch_in = '0;
  logic [7:0]  patch_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ecc_sector_check uut (.*);

  // reference model state
  int m_valid = 0, m_status = 0, m_byte = 0, m_bit = 0;

  function automatic int bitof(input int v, input int p);
    return (v >> p) & 1;
  endfunction

  task automatic model_eval(input int s, input int c);
    int syn, ones, okpairs;
    syn = s ^ c;
    ones = 0; okpairs = 0;
    for (int p = 0; p < 24; p++) ones += bitof(syn, p);
    for (int q = 0; q < 12; q++)
      if (bitof(syn, 2*q) + bitof(syn, 2*q+1) == 1) okpairs++;
    m_byte = 0; m_bit = 0;
    for (int q = 0; q < 9; q++) m_byte += bitof(syn, 2*q+1) * (1 << q);
    for (int q = 0; q < 3; q++) m_bit += bitof(syn, 19+2*q) * (1 << q);
    if (syn == 0 || s == 24'hFFFFFF) m_status = 0;      // R1 R2
    else if (okpairs == 12)          m_status = 1;      // R3
    else if (ones == 1)              m_status = 2;      // R6
    else                             m_status = 3;      // R7
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid = 0; m_status = 0; m_byte = 0; m_bit = 0;  // R11
    end else begin
      cycles++;
      m_valid = chk_valid;
      if (chk_valid) model_eval(int'(stored_ecc), int'(calc_ecc));
    end
  end

  task automatic fail(input string req, input int act, input int exp);
    errors++;
    $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    int ep;
    if (!done) begin
      checks++;
      if (res_valid !== m_valid[0]) fail("R10 valid", res_valid, m_valid);
      if (status !== m_status[1:0])
        fail(m_status == 0 ? "R1/R2/R11 status" : m_status == 1 ? "R3 status" :
             m_status == 2 ? "R6 status" : "R7 status", status, m_status);
      if ((m_status == 1 || !rst_n) && err_byte !== m_byte[8:0]) fail("R4 byte", err_byte, m_byte);
      if ((m_status == 1 || !rst_n) && err_bit !== m_bit[2:0]) fail("R5 bit", err_bit, m_bit);
      ep = patch_in;
      if (m_status == 1 && int'(patch_idx) == m_byte) ep = ep ^ (1 << m_bit);
      if (patch_out !== ep[7:0])
        fail(m_status == 1 ? "R8 patch" : "R9 patch", patch_out, ep);
    end
  end

  task automatic strobe(input logic [23:0] s, input logic [23:0] c);
    @(posedge clk); #1;
    chk_valid = 1'b1; stored_ecc = s; calc_ecc = c;
    @(posedge clk); #1;
    chk_valid = 1'b0; stored_ecc = $urandom; calc_ecc = $urandom;
  endtask

  task automatic probe(input logic [8:0] idx, input logic [7:0] b);
    @(posedge clk); #1;
    patch_idx = idx; patch_in = b;
  endtask

  // build a correctable syndrome for a chosen offset and bit number
  function automatic logic [23:0] make_syn(input int ofs, input int bn);
    logic [23:0] r;
    int loc;
    loc = ofs | (bn << 9);
    r = '0;
    for (int q = 0; q < 12; q++)
      if ((loc >> q) & 1) r[2*q+1] = 1'b1; else r[2*q] = 1'b1;
    return r;
  endfunction

  task automatic fix_case(input int ofs, input int bn);
    logic [23:0] c;
    c = $urandom;
    if (c == 24'hFFFFFF) c = 24'h123456;
    strobe(c ^ make_syn(ofs, bn), c);
    // R8: flip at the offset, R9: neighbours pass
    probe(ofs[8:0], $urandom);
    probe(ofs[8:0] + 9'd1, $urandom);
    probe(ofs[8:0] - 9'd1, $urandom);
    probe(ofs[8:0], 8'h00);
    probe(ofs[8:0], 8'hFF);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;                      // R11 checked during and after reset
    repeat (4) @(posedge clk);
    // R1: zero syndrome
    strobe(24'h3C5A96, 24'h3C5A96);
    strobe(24'h000000, 24'h000000);
    // R2: blank stored bytes with correctable, single and random syndromes
    strobe(24'hFFFFFF, 24'hFFFFFF ^ make_syn(17, 4));
    strobe(24'hFFFFFF, 24'hFFFFFE);
    strobe(24'hFFFFFF, 24'h000000);
    probe(9'd17, 8'hA5);                  // R9 after blank
    // R3 R4 R5 R8: corner offsets and every bit number
    for (int bn = 0; bn < 8; bn++) begin
      fix_case(0, bn);
      fix_case(511, bn);
    end
    for (int k = 0; k < 40; k++) fix_case($urandom_range(0, 511), $urandom_range(0, 7));
    // R10: result held while stream runs without strobes
    fix_case(300, 6);
    repeat (6) probe(9'd300, $urandom);
    // R6: every single-bit syndrome
    for (int p = 0; p < 24; p++) begin
      strobe(24'h0F0F0F ^ (24'h1 << p), 24'h0F0F0F);
      probe(9'd0, $urandom);              // R9 with status 10
    end
    // R7: two-bit and random syndromes
    strobe(24'h000003, 24'h000000);
    strobe(24'h800001, 24'h000000);
    for (int k = 0; k < 60; k++) begin
      strobe($urandom, $urandom);
      probe($urandom, $urandom);
    end
    // R10: back-to-back strobes
    @(posedge clk); #1;
    chk_valid = 1'b1; stored_ecc = make_syn(5, 1); calc_ecc = '0;
    @(posedge clk); #1;
    stored_ecc = 24'h000010;
    @(posedge clk); #1;
    chk_valid = 1'b0;
    repeat (3) @(posedge clk);
    #2 done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule